// File: doc/BRIEF.md
# Program Memory Block Protection Unit

This unit sits between a program memory array and the two paths that reach it: table reads and writes issued by running code, and the external programming port. It splits the address space into a boot region and a set of numbered user blocks. Each region holds three protection flags: write-protect, cross-block read-protect and code-protect. A flag is active when it is 0.

For every request the unit takes the target address, the program counter of the instruction that issued it, and a flag that marks the request as coming from the external port. One cycle later it reports whether a write may proceed. For a read, it either returns the array data or forces the data to zero. The same unit keeps the protection flags. Ordinary writes can only clear them. A block erase or a chip erase sets them again, and only a request from the external port can start an erase.

Top module: `pmprot_top`

## Requirements
- R1: Region decode with default parameters. Region 0 is the boot area 000000h–0007FFh. User block k covers 004000h·k to 004000h·k+3FFFh for k = 0..3, except that block 0 starts at 000800h. Flag vector bit 0 belongs to the boot area and bit k+1 belongs to user block k.
- R2: An internal table write to a region whose write-protect bit is 0 is refused (write_allow = 0), whatever the program counter is.
- R3: An internal table read of a region whose read-protect bit is 0 returns the array data when the program counter lies in that same region.
- R4: An internal table read of a region whose read-protect bit is 0 returns zero data with read_zero = 1 when the program counter lies in a different region.
- R5: Code-protect bits have no effect on internal requests.
- R6: External-port requests are governed only by the code-protect bit of the target region. When that bit is 0, writes are refused and reads return zero. When it is 1, the request passes.
- R7: A protection-register write ANDs each flag with the supplied value. Flags can go from 1 to 0, and a 1 written over a 0 leaves it at 0.
- R8: A block erase sets all three flags of the selected region to 1. It acts only when erase_ext = 1 and is ignored otherwise.
- R9: A chip erase with erase_ext = 1 sets every flag to 1. It wins over a protection-register write in the same cycle.
- R10: With write-protect and read-protect both at 1, internal reads and writes to a region are unrestricted.
- R11: Addresses above 00FFFFh are unprotected. Writes there are allowed, and reads there pass data through from any program counter and from either path.
- R12: resp_valid, write_allow, read_zero and rd_data are registered and describe the request presented one clock earlier. write_allow is 0 for reads, and read_zero is 0 for writes.
- R13: After reset all flags are 1 and resp_valid, write_allow and read_zero are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = table write, 0 = table read |
| req_ext | input | 1 | Request comes from the external programming port |
| req_addr | input | 24 | Target address |
| req_pc | input | 24 | Program counter of the issuing instruction |
| arr_rdata | input | 8 | Read data from the array for this request |
| prot_wr_en | input | 1 | Protection-register write strobe |
| prot_wr_wrp | input | 5 | Write-protect values to AND in |
| prot_wr_rdp | input | 5 | Read-protect values to AND in |
| prot_wr_cpp | input | 5 | Code-protect values to AND in |
| erase_ext | input | 1 | Erase request originates from the external port |
| blk_erase | input | 1 | Block erase pulse |
| erase_sel | input | 3 | Region index for block erase (0 boot, k+1 user block k) |
| chip_erase | input | 1 | Chip erase pulse |
| resp_valid | output | 1 | Response for the previous cycle's request |
| write_allow | output | 1 | Write may proceed |
| read_zero | output | 1 | Read data was forced to zero |
| rd_data | output | 8 | Filtered read data |
| wrp_q | output | 5 | Current write-protect flags |
| rdp_q | output | 5 | Current read-protect flags |
| cpp_q | output | 5 | Current code-protect flags |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, a 2 KiB boot area and four user blocks of 16 KiB. With these values every region edge (0007FFh/000800h, 00FFFFh/010000h) and the unmapped space can be reached with directed addresses. The bench keeps its own copy of the flags and decodes regions by explicit address ranges. It can therefore predict the result of each access after every sequence of clears and erases, including an erase sent on the internal path and a chip erase that arrives together with a register write.

// File: rtl/pmprot_pkg.sv
`timescale 1ns/1ps
package pmprot_pkg;

  // Map an address to a region index: 0 = boot, k+1 = user block k,
  // nublk+1 = outside every protected region.
  function automatic int unsigned region_of(input logic [31:0] a,
                                            input int unsigned boot_sz,
                                            input int unsigned shift,
                                            input int unsigned nublk);
    int unsigned blk;
    if (a < boot_sz) return 0;
    blk = a >> shift;
    if (blk < nublk) return blk + 1;
    return nublk + 1;
  endfunction

  // Write permission for a mapped region.
  function automatic logic write_ok(input logic ext, input logic cp, input logic wp);
    return ext ? cp : wp;
  endfunction

  // Read blanking for a mapped region.
  function automatic logic read_blank(input logic ext, input logic cp,
                                      input logic rp, input logic same_region);
    return ext ? !cp : (!rp && !same_region);
  endfunction

endpackage

// File: rtl/pmprot_region_dec.sv
`timescale 1ns/1ps
module pmprot_region_dec #(
  parameter int ADDR_W    = 24,
  parameter int BOOT_SZ   = 2048,
  parameter int BLK_SHIFT = 14,
  parameter int NUM_UBLK  = 4,
  parameter int RW        = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RW-1:0]     region,
  output logic              in_map
);
  localparam int NONE_IDX = NUM_UBLK + 1;

  always_comb begin
    region = RW'(pmprot_pkg::region_of(32'(addr), BOOT_SZ, BLK_SHIFT, NUM_UBLK));
    in_map = (region != RW'(NONE_IDX));
  end
endmodule

// File: rtl/pmprot_bits.sv
`timescale 1ns/1ps
module pmprot_bits #(
  parameter int NB = 5,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NB-1:0] wr_wrp,
  input  logic [NB-1:0] wr_rdp,
  input  logic [NB-1:0] wr_cpp,
  input  logic          erase_ext,
  input  logic          blk_erase,
  input  logic [RW-1:0] erase_sel,
  input  logic          chip_erase,
  output logic [NB-1:0] wrp_q,
  output logic [NB-1:0] rdp_q,
  output logic [NB-1:0] cpp_q,
  output logic          chip_ok,
  output logic          blk_ok
);
  assign chip_ok = erase_ext && chip_erase;
  assign blk_ok  = erase_ext && blk_erase;

  for (genvar i = 0; i < NB; i++) begin : g_region
    logic hit;
    assign hit = chip_ok || (blk_ok && (erase_sel == RW'(i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wrp_q[i] <= 1'b1;
        rdp_q[i] <= 1'b1;
        cpp_q[i] <= 1'b1;
      end else if (hit) begin
        wrp_q[i] <= 1'b1;
        rdp_q[i] <= 1'b1;
        cpp_q[i] <= 1'b1;
      end else if (wr_en) begin
        wrp_q[i] <= wrp_q[i] & wr_wrp[i];
        rdp_q[i] <= rdp_q[i] & wr_rdp[i];
        cpp_q[i] <= cpp_q[i] & wr_cpp[i];
      end
    end
  end
endmodule

// File: rtl/pmprot_judge.sv
`timescale 1ns/1ps
module pmprot_judge #(
  parameter int NB = 5,
  parameter int RW = 3
) (
  input  logic          req_ext,
  input  logic [RW-1:0] tgt_region,
  input  logic          tgt_in_map,
  input  logic [RW-1:0] pc_region,
  input  logic [NB-1:0] wrp_q,
  input  logic [NB-1:0] rdp_q,
  input  logic [NB-1:0] cpp_q,
  output logic          wr_ok,
  output logic          rd_blank
);
  logic wp_t, rp_t, cp_t;

  always_comb begin
    wp_t = 1'b1;
    rp_t = 1'b1;
    cp_t = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (tgt_region == RW'(i)) begin
        wp_t = wrp_q[i];
        rp_t = rdp_q[i];
        cp_t = cpp_q[i];
      end
    end
    if (tgt_in_map) begin
      wr_ok    = pmprot_pkg::write_ok(req_ext, cp_t, wp_t);
      rd_blank = pmprot_pkg::read_blank(req_ext, cp_t, rp_t, pc_region == tgt_region);
    end else begin
      wr_ok    = 1'b1;
      rd_blank = 1'b0;
    end
  end
endmodule

// File: rtl/pmprot_top.sv
`timescale 1ns/1ps
module pmprot_top #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int BOOT_SZ   = 2048,
  parameter int BLK_SHIFT = 14,
  parameter int NUM_UBLK  = 4,
  localparam int NB       = NUM_UBLK + 1,
  localparam int RW       = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ext,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              prot_wr_en,
  input  logic [NB-1:0]     prot_wr_wrp,
  input  logic [NB-1:0]     prot_wr_rdp,
  input  logic [NB-1:0]     prot_wr_cpp,
  input  logic              erase_ext,
  input  logic              blk_erase,
  input  logic [RW-1:0]     erase_sel,
  input  logic              chip_erase,
  output logic              resp_valid,
  output logic              write_allow,
  output logic              read_zero,
  output logic [DATA_W-1:0] rd_data,
  output logic [NB-1:0]     wrp_q,
  output logic [NB-1:0]     rdp_q,
  output logic [NB-1:0]     cpp_q
);
  logic [RW-1:0] tgt_region, pc_region;
  logic          tgt_in_map, pc_in_map;
  logic          wr_ok, rd_blank;
  logic          chip_ok, blk_ok;
  logic          is_rd, is_wr;

  pmprot_region_dec #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ), .BLK_SHIFT(BLK_SHIFT),
                      .NUM_UBLK(NUM_UBLK), .RW(RW)) u_tgt_dec (
    .addr(req_addr), .region(tgt_region), .in_map(tgt_in_map));

  pmprot_region_dec #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ), .BLK_SHIFT(BLK_SHIFT),
                      .NUM_UBLK(NUM_UBLK), .RW(RW)) u_pc_dec (
    .addr(req_pc), .region(pc_region), .in_map(pc_in_map));

  pmprot_bits #(.NB(NB), .RW(RW)) u_bits (
    .clk(clk), .rst_n(rst_n), .wr_en(prot_wr_en),
    .wr_wrp(prot_wr_wrp), .wr_rdp(prot_wr_rdp), .wr_cpp(prot_wr_cpp),
    .erase_ext(erase_ext), .blk_erase(blk_erase), .erase_sel(erase_sel),
    .chip_erase(chip_erase), .wrp_q(wrp_q), .rdp_q(rdp_q), .cpp_q(cpp_q),
    .chip_ok(chip_ok), .blk_ok(blk_ok));

  pmprot_judge #(.NB(NB), .RW(RW)) u_judge (
    .req_ext(req_ext), .tgt_region(tgt_region), .tgt_in_map(tgt_in_map),
    .pc_region(pc_in_map ? pc_region : RW'(NB)),
    .wrp_q(wrp_q), .rdp_q(rdp_q), .cpp_q(cpp_q),
    .wr_ok(wr_ok), .rd_blank(rd_blank));

  assign is_rd = req_valid && !req_write;
  assign is_wr = req_valid && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      write_allow <= 1'b0;
      read_zero   <= 1'b0;
      rd_data     <= '0;
    end else begin
      resp_valid  <= req_valid;
      write_allow <= is_wr && wr_ok;
      read_zero   <= is_rd && rd_blank;
      rd_data     <= (is_rd && !rd_blank) ? arr_rdata : '0;
    end
  end
endmodule

// File: rtl/pmprot_chk.sv
`timescale 1ns/1ps
module pmprot_chk #(
  parameter int NB     = 5,
  parameter int RW     = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ext,
  input logic [RW-1:0]     tgt_region,
  input logic              tgt_in_map,
  input logic [NB-1:0]     wrp_q,
  input logic [NB-1:0]     rdp_q,
  input logic [NB-1:0]     cpp_q,
  input logic              chip_ok,
  input logic              blk_ok,
  input logic [RW-1:0]     erase_sel,
  input logic              resp_valid,
  input logic              write_allow,
  input logic              read_zero,
  input logic [DATA_W-1:0] rd_data
);
  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (resp_valid == $past(req_valid)));  // R12

  AST_WRP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_ext && tgt_in_map && !wrp_q[tgt_region]) |=> !write_allow);  // R2

  AST_CP_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ext && tgt_in_map && !cpp_q[tgt_region])
      |=> (!write_allow && (read_zero == $past(!req_write))));  // R6

  AST_UNMAPPED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tgt_in_map) |=> (!read_zero && (write_allow == $past(req_write))));  // R11

  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    read_zero |-> (rd_data == '0));  // R4

  AST_NO_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_ok && !blk_ok) |=> (((wrp_q & ~$past(wrp_q)) == '0) &&
                               ((rdp_q & ~$past(rdp_q)) == '0) &&
                               ((cpp_q & ~$past(cpp_q)) == '0)));  // R7

  AST_CHIP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    chip_ok |=> ((&wrp_q) && (&rdp_q) && (&cpp_q)));  // R9

  AST_BLK_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ok && (erase_sel < RW'(NB))) |=>
      (wrp_q[$past(erase_sel)] && rdp_q[$past(erase_sel)] && cpp_q[$past(erase_sel)]));  // R8
endmodule

bind pmprot_top pmprot_chk #(.NB(NB), .RW(RW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ext(req_ext), .tgt_region(tgt_region), .tgt_in_map(tgt_in_map),
  .wrp_q(wrp_q), .rdp_q(rdp_q), .cpp_q(cpp_q), .chip_ok(chip_ok),
  .blk_ok(blk_ok), .erase_sel(erase_sel), .resp_valid(resp_valid),
  .write_allow(write_allow), .read_zero(read_zero), .rd_data(rd_data));

// File: tb/tb_pmprot_top.sv
`timescale 1ns/1ps
module tb_pmprot_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
  logic [23:0] req_addr = '0, req_pc = '0;
  logic [7:0]  arr_rdata = '0;
  logic        prot_wr_en = 1'b0;
  logic [4:0]  prot_wr_wrp = '1, prot_wr_rdp = '1, prot_wr_cpp = '1;
  logic        erase_ext = 1'b0, blk_erase = 1'b0, chip_erase = 1'b0;
  logic [2:0]  erase_sel = '0;
  logic        resp_valid, write_allow, read_zero;
  logic [7:0]  rd_data;
  logic [4:0]  wrp_q, rdp_q, cpp_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [4:0] m_wrp = '1, m_rdp = '1, m_cpp = '1;

  always #5 clk = ~clk;

  pmprot_top dut (.*);

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Region numbering from explicit address ranges: 0 boot, 1..4 user, 5 none.
  function automatic int ref_region(input logic [23:0] a);
    if (a <= 24'h0007FF) return 0;
    if (a <= 24'h003FFF) return 1;
    if (a <= 24'h007FFF) return 2;
    if (a <= 24'h00BFFF) return 3;
    if (a <= 24'h00FFFF) return 4;
    return 5;
  endfunction

  task automatic access(input logic wr, input logic ext, input logic [23:0] addr,
                        input logic [23:0] pc, input logic [7:0] data, input string tag);
    int r, p;
    logic e_allow, e_zero;
    logic [7:0] e_data;
    r = ref_region(addr);
    p = ref_region(pc);
    if (r == 5) begin
      e_allow = wr; e_zero = 1'b0;
    end else if (ext) begin
      e_allow = wr && m_cpp[r]; e_zero = !wr && !m_cpp[r];
    end else begin
      e_allow = wr && m_wrp[r]; e_zero = !wr && !m_rdp[r] && (p != r);
    end
    e_data = (!wr && !e_zero) ? data : 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_ext = ext;
    req_addr = addr; req_pc = pc; arr_rdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    check(32'(resp_valid), 1, {tag, " R12 resp_valid"});
    check(32'(write_allow), 32'(e_allow), {tag, " write_allow"});
    check(32'(read_zero), 32'(e_zero), {tag, " read_zero"});
    check(32'(rd_data), 32'(e_data), {tag, " rd_data"});
    @(negedge clk);
    check(32'(resp_valid), 0, {tag, " R12 resp_valid idle"});
  endtask

  task automatic check_bits(input string tag);
    check(32'(wrp_q), 32'(m_wrp), {tag, " wrp_q"});
    check(32'(rdp_q), 32'(m_rdp), {tag, " rdp_q"});
    check(32'(cpp_q), 32'(m_cpp), {tag, " cpp_q"});
  endtask

  task automatic prot_write(input logic [4:0] w, input logic [4:0] r, input logic [4:0] c,
                            input string tag);
    @(negedge clk);
    prot_wr_en = 1'b1; prot_wr_wrp = w; prot_wr_rdp = r; prot_wr_cpp = c;
    @(negedge clk);
    prot_wr_en = 1'b0; prot_wr_wrp = '1; prot_wr_rdp = '1; prot_wr_cpp = '1;
    m_wrp &= w; m_rdp &= r; m_cpp &= c;
    check_bits({tag, " R7"});
  endtask

  task automatic erase_block(input logic ext, input logic [2:0] sel, input string tag);
    @(negedge clk);
    erase_ext = ext; blk_erase = 1'b1; erase_sel = sel;
    @(negedge clk);
    erase_ext = 1'b0; blk_erase = 1'b0;
    if (ext) begin
      m_wrp[sel] = 1'b1; m_rdp[sel] = 1'b1; m_cpp[sel] = 1'b1;
    end
    check_bits({tag, " R8"});
  endtask

  task automatic test_reset();
    check(32'(resp_valid), 0, "R13 resp_valid");
    check(32'(write_allow), 0, "R13 write_allow");
    check(32'(read_zero), 0, "R13 read_zero");
    check_bits("R13 reset flags");
  endtask

  task automatic test_open();
    access(1, 0, 24'h008123, 24'h000100, 8'h11, "R10 write other block");
    access(0, 0, 24'h00C010, 24'h004000, 8'hA5, "R10 read other block");
    access(0, 0, 24'h000010, 24'h00F000, 8'h3C, "R10 read boot");
  endtask

  task automatic test_write_protect();
    prot_write(5'b11011, 5'b11111, 5'b11111, "clear wrp blk1");
    access(1, 0, 24'h004000, 24'h004100, 8'h00, "R2 write own block");
    access(1, 0, 24'h007FFF, 24'h000100, 8'h00, "R2 write from boot");
    access(1, 0, 24'h008000, 24'h004100, 8'h00, "R2 neighbour open");
    access(0, 0, 24'h004000, 24'h000200, 8'h5A, "R2 read unaffected");
  endtask

  task automatic test_read_protect();
    prot_write(5'b11111, 5'b11101, 5'b11111, "clear rdp blk0");
    access(0, 0, 24'h001000, 24'h002000, 8'h77, "R3 read same block");
    access(0, 0, 24'h001000, 24'h005000, 8'h77, "R4 read from blk1");
    access(0, 0, 24'h000800, 24'h0007FF, 8'h66, "R1 R4 boot edge pc");
    access(0, 0, 24'h000800, 24'h000800, 8'h66, "R1 R3 blk0 edge pc");
    access(0, 0, 24'h0007FF, 24'h000900, 8'h44, "R1 boot target open");
    access(1, 0, 24'h001000, 24'h005000, 8'h00, "R4 write not blocked by rdp");
  endtask

  task automatic test_no_set();
    prot_write(5'b11111, 5'b11111, 5'b11111, "write ones");
    prot_write(5'b01111, 5'b11111, 5'b01111, "clear blk3 wrp cpp");
  endtask

  task automatic test_code_protect();
    access(0, 0, 24'h00C000, 24'h000000, 8'h99, "R5 internal read cp0");
    access(1, 0, 24'h008000, 24'h000000, 8'h00, "R5 internal write blk2");
    access(0, 1, 24'h00C000, 24'h000000, 8'h99, "R6 ext read cp0");
    access(1, 1, 24'h00C000, 24'h000000, 8'h00, "R6 ext write cp0");
    access(1, 1, 24'h004000, 24'h000000, 8'h00, "R6 ext write blk1 cp1");
    access(0, 1, 24'h001000, 24'h00F000, 8'h21, "R6 ext read blk0 cp1");
  endtask

  task automatic test_unmapped();
    prot_write(5'b00000, 5'b00000, 5'b00000, "clear all");
    access(1, 0, 24'h010000, 24'h000000, 8'h00, "R11 write above map");
    access(0, 0, 24'h010000, 24'h004000, 8'hBE, "R11 read above map");
    access(0, 1, 24'hFFFFFF, 24'h000000, 8'hEF, "R11 ext read top");
    access(0, 0, 24'h00FFFF, 24'h000000, 8'hEF, "R1 R4 last mapped byte");
  endtask

  task automatic test_erase();
    erase_block(0, 3'd2, "internal erase ignored");
    erase_block(1, 3'd2, "ext erase blk1");
    access(1, 0, 24'h004000, 24'h000000, 8'h00, "R8 blk1 write after erase");
    access(0, 0, 24'h008000, 24'h000000, 8'h31, "R8 blk2 still protected");
    erase_block(1, 3'd0, "ext erase boot");
  endtask

  task automatic test_chip_erase();
    @(negedge clk);
    erase_ext = 1'b0; chip_erase = 1'b1;
    @(negedge clk);
    chip_erase = 1'b0;
    check_bits("R9 internal chip erase ignored");
    @(negedge clk);
    erase_ext = 1'b1; chip_erase = 1'b1;
    prot_wr_en = 1'b1; prot_wr_wrp = '0; prot_wr_rdp = '0; prot_wr_cpp = '0;
    @(negedge clk);
    erase_ext = 1'b0; chip_erase = 1'b0;
    prot_wr_en = 1'b0; prot_wr_wrp = '1; prot_wr_rdp = '1; prot_wr_cpp = '1;
    m_wrp = '1; m_rdp = '1; m_cpp = '1;
    check_bits("R9 chip erase beats write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_open();
    test_write_protect();
    test_read_protect();
    test_no_set();
    test_code_protect();
    test_unmapped();
    test_erase();
    test_chip_erase();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule